// File: doc/BRIEF.md
# OSD Row and Field Interrupt Generator

This block sits beside an on-screen-display controller. It watches the horizontal and vertical sync inputs and turns them into two separate, recurring interrupt events. Software uses these events to reprogram the display. The field event marks the start of a new field. The row event marks the start of each text row, and software has the length of that row to prepare the next one.

Both sync inputs pass through a synchronizer. Their active level comes from a configuration pin, so a leading edge is the move into the active level, whatever the polarity. After a field edge, the block counts horizontal sync edges. The first edge starts text row 0, and from then on a row boundary falls every 18 scan lines. A row that the double-height request marks at its start lasts 36 lines instead. The row index counts up to a configured maximum and stops there. No further row events come until the next field edge.

Each event sets a sticky pending bit. Software clears a pending bit with a one-cycle pulse. A per-source enable selects which pending bits drive the single interrupt output.

Top module: `osd_sync_irq`

## Requirements
- R1: While reset is held and on the first cycle after it, `irq_pend` is 0, `irq` is 0 and `row_index` is 0.
- R2: A leading edge on the vertical sync input sets pending bit 1, the field bit.
- R3: After a field edge, the first leading edge on the horizontal sync input sets pending bit 0, the row bit, and `row_index` reads 0.
- R4: In a normal row, the 18th horizontal leading edge after the row's first edge starts the next row. It sets the row bit and adds one to `row_index`. The 1st to 17th edges set nothing.
- R5: `dbl_height` is sampled at each row start. A row that starts with it at 1 lasts 36 horizontal edges. Changing `dbl_height` in the middle of a row does not change that row's length.
- R6: `row_index` never goes above MAX_ROWS-1. Once the last row ends, further horizontal edges set no row bit and leave `row_index` unchanged until the next field edge.
- R7: A one-cycle pulse on `irq_clr[i]` clears pending bit i. If that bit's event happens in the same cycle as the clear, the bit stays set.
- R8: `irq` is the OR over i of `irq_pend[i]` AND `irq_en[i]`. A pending bit is set by its event even when its enable is 0.
- R9: With `sync_act_high` = 1 a leading edge is a 0-to-1 change on a sync input. With `sync_act_high` = 0 it is a 1-to-0 change. Holding the active level or returning to the idle level produces no event.
- R10: A field edge sets `row_index` to 0 and restarts line counting. Horizontal edges that arrive after reset and before any field edge produce no row event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_in | input | 1 | Raw horizontal sync, asynchronous |
| vsync_in | input | 1 | Raw vertical sync, asynchronous |
| sync_act_high | input | 1 | 1: syncs are active high; 0: active low |
| dbl_height | input | 1 | Double-height request for the row that starts next |
| irq_en | input | 2 | Enable per source (bit 0 row, bit 1 field) |
| irq_clr | input | 2 | Clear pulse per source (write-one-to-clear) |
| irq | output | 1 | Combined interrupt |
| irq_pend | output | 2 | Pending bits (bit 0 row, bit 1 field) |
| row_index | output | ROW_W | Index of the current text row |

## Verification
The assertions take for granted that `sync_act_high` changes only while reset is held. They also assume each sync pulse and each gap between pulses lasts at least one clock after synchronization, so every edge produces exactly one single-cycle detection pulse. The stimulus changes polarity only inside a reset window and drives horizontal pulses of two cycles within eight-cycle lines. Vertical pulses last three cycles or more and are placed between lines. All inputs change on the falling clock edge, away from the sampling edge.

// File: rtl/osd_irq_pkg.sv
package osd_irq_pkg;

    typedef enum logic [1:0] {
        TRK_IDLE,
        TRK_ARMED,
        TRK_ROWS,
        TRK_DONE
    } trk_state_e;

    localparam int SRC_ROW   = 0;
    localparam int SRC_FIELD = 1;
    localparam int N_SRC     = 2;

    typedef struct packed {
        logic field;
        logic row;
    } irq_evt_t;

    function automatic logic to_active(logic raw, logic act_high);
        return act_high ? raw : ~raw;
    endfunction

endpackage

// File: rtl/osd_sync_edge.sv
module osd_sync_edge
    import osd_irq_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    input  logic act_high,
    output logic lead
);
    logic [STAGES:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= {pipe[STAGES-1:0], raw};
    end

    always_comb begin
        lead = to_active(pipe[STAGES-1], act_high) & ~to_active(pipe[STAGES], act_high);
    end

    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        lead |=> !lead);

endmodule

// File: rtl/osd_row_tracker.sv
module osd_row_tracker
    import osd_irq_pkg::*;
#(
    parameter int LINES_PER_ROW = 18,
    parameter int MAX_ROWS      = 12,
    parameter int LINE_W        = 6,
    parameter int ROW_W         = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hs_lead,
    input  logic             vs_lead,
    input  logic             dbl_req,
    output logic             row_evt,
    output logic [ROW_W-1:0] row_idx
);
    localparam logic [LINE_W-1:0] LEN_N    = LINE_W'(LINES_PER_ROW);
    localparam logic [LINE_W-1:0] LEN_D    = LINE_W'(2 * LINES_PER_ROW);
    localparam logic [ROW_W-1:0]  LAST_ROW = ROW_W'(MAX_ROWS - 1);

    trk_state_e        st, st_n;
    logic [LINE_W-1:0] line_cnt, line_n, cur_len;
    logic [ROW_W-1:0]  row_n;
    logic              row_dbl, dbl_n;

    always_comb begin
        cur_len = row_dbl ? LEN_D : LEN_N;
        st_n    = st;
        line_n  = line_cnt;
        row_n   = row_idx;
        dbl_n   = row_dbl;
        row_evt = 1'b0;
        if (vs_lead) begin
            st_n   = TRK_ARMED;
            line_n = '0;
            row_n  = '0;
        end else if (hs_lead) begin
            unique case (st)
                TRK_ARMED: begin
                    st_n    = TRK_ROWS;
                    line_n  = LINE_W'(1);
                    dbl_n   = dbl_req;
                    row_evt = 1'b1;
                end
                TRK_ROWS: begin
                    if (line_cnt == cur_len) begin
                        if (row_idx == LAST_ROW) begin
                            st_n = TRK_DONE;
                        end else begin
                            row_n   = row_idx + 1'b1;
                            line_n  = LINE_W'(1);
                            dbl_n   = dbl_req;
                            row_evt = 1'b1;
                        end
                    end else begin
                        line_n = line_cnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= TRK_IDLE;
            line_cnt <= '0;
            row_idx  <= '0;
            row_dbl  <= 1'b0;
        end else begin
            st       <= st_n;
            line_cnt <= line_n;
            row_idx  <= row_n;
            row_dbl  <= dbl_n;
        end
    end

    assert_row_bound_R6: assert property (@(posedge clk) disable iff (rst)
        row_idx <= LAST_ROW);
    assert_vs_restart_R10: assert property (@(posedge clk) disable iff (rst)
        vs_lead |=> (row_idx == '0));
    assert_evt_on_hs_R3: assert property (@(posedge clk) disable iff (rst)
        row_evt |-> hs_lead);
    assert_line_bound_R4: assert property (@(posedge clk) disable iff (rst)
        line_cnt <= LEN_D);
    assert_dbl_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!row_evt && !vs_lead) |=> $stable(row_dbl));

endmodule

// File: rtl/osd_irq_pending.sv
module osd_irq_pending
    import osd_irq_pkg::*;
#(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] en,
    output logic [N-1:0] pend,
    output logic         irq
);
    for (genvar i = 0; i < N; i++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst)         pend[i] <= 1'b0;
            else if (set[i]) pend[i] <= 1'b1;
            else if (clr[i]) pend[i] <= 1'b0;
        end

        assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
            set[i] |=> pend[i]);
        assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
            (clr[i] && !set[i]) |=> !pend[i]);
    end

    always_comb irq = |(pend & en);

endmodule

// File: rtl/osd_sync_irq.sv
module osd_sync_irq
    import osd_irq_pkg::*;
#(
    parameter int LINES_PER_ROW = 18,
    parameter int MAX_ROWS      = 12,
    parameter int SYNC_STAGES   = 2,
    localparam int ROW_W        = (MAX_ROWS > 1) ? $clog2(MAX_ROWS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hsync_in,
    input  logic             vsync_in,
    input  logic             sync_act_high,
    input  logic             dbl_height,
    input  logic [1:0]       irq_en,
    input  logic [1:0]       irq_clr,
    output logic             irq,
    output logic [1:0]       irq_pend,
    output logic [ROW_W-1:0] row_index
);
    localparam int LINE_W = $clog2(2 * LINES_PER_ROW + 1);

    logic [N_SRC-1:0] raw_sync, sync_lead;
    irq_evt_t         evt;

    assign raw_sync[SRC_ROW]   = hsync_in;
    assign raw_sync[SRC_FIELD] = vsync_in;

    for (genvar s = 0; s < N_SRC; s++) begin : g_sync
        osd_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
            .clk      (clk),
            .rst      (rst),
            .raw      (raw_sync[s]),
            .act_high (sync_act_high),
            .lead     (sync_lead[s])
        );
    end

    osd_row_tracker #(
        .LINES_PER_ROW (LINES_PER_ROW),
        .MAX_ROWS      (MAX_ROWS),
        .LINE_W        (LINE_W),
        .ROW_W         (ROW_W)
    ) u_trk (
        .clk     (clk),
        .rst     (rst),
        .hs_lead (sync_lead[SRC_ROW]),
        .vs_lead (sync_lead[SRC_FIELD]),
        .dbl_req (dbl_height),
        .row_evt (evt.row),
        .row_idx (row_index)
    );

    assign evt.field = sync_lead[SRC_FIELD];

    osd_irq_pending #(.N(N_SRC)) u_pend (
        .clk  (clk),
        .rst  (rst),
        .set  (evt),
        .clr  (irq_clr),
        .en   (irq_en),
        .pend (irq_pend),
        .irq  (irq)
    );

    assert_field_sets_R2: assert property (@(posedge clk) disable iff (rst)
        sync_lead[SRC_FIELD] |=> irq_pend[SRC_FIELD]);

endmodule

// File: tb/sim_osd_sync_irq.sv
`timescale 1ns/1ps
module sim_osd_sync_irq;
    localparam int MAXR = 12;
    localparam int RW   = $clog2(MAXR);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hs = 1'b0, vs = 1'b0, pol = 1'b1, dbl = 1'b0;
    logic [1:0] en = 2'b11, clr = 2'b00;
    logic irq;
    logic [1:0] pend;
    logic [RW-1:0] rowi;

    int checks = 0, errors = 0;
    bit started = 0, finished = 0;

    always #5 clk = ~clk;

    osd_sync_irq u0 (
        .clk(clk), .rst(rst), .hsync_in(hs), .vsync_in(vs),
        .sync_act_high(pol), .dbl_height(dbl), .irq_en(en), .irq_clr(clr),
        .irq(irq), .irq_pend(pend), .row_index(rowi)
    );

    // behavioural reference
    int ms, ml, mr;
    bit md;
    bit [1:0] mp;
    bit hd1, hd2, hd3, vd1, vd2, vd3;

    function automatic bit act(bit x);
        return pol ? x : !x;
    endfunction

    always @(posedge clk) begin
        bit hl, vl;
        bit [1:0] st;
        if (rst) begin
            ms = 0; ml = 0; mr = 0; md = 0; mp = 0;
            {hd1, hd2, hd3, vd1, vd2, vd3} = '0;
        end else begin
            hl = act(hd2) && !act(hd3);
            vl = act(vd2) && !act(vd3);
            st = 2'b00;
            if (vl) begin
                ms = 1; ml = 0; mr = 0; st[1] = 1'b1;
            end else if (hl) begin
                if (ms == 1) begin
                    ms = 2; ml = 1; md = dbl; st[0] = 1'b1;
                end else if (ms == 2) begin
                    if (ml == (md ? 36 : 18)) begin
                        if (mr == MAXR - 1) ms = 3;
                        else begin mr++; ml = 1; md = dbl; st[0] = 1'b1; end
                    end else ml++;
                end
            end
            mp = (mp & ~clr) | st;
            hd3 = hd2; hd2 = hd1; hd1 = hs;
            vd3 = vd2; vd2 = vd1; vd1 = vs;
        end
        started = 1;
    end

    task automatic check(string tag, int actual, int expected);
        checks++;
        if (actual !== expected) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, actual, expected, $time);
        end
    endtask

    always @(negedge clk) begin
        #2;
        if (started && !finished) begin
            check("R7 model pending", int'(pend), int'(mp));
            check("R8 model irq", int'(irq), int'(|(mp & en)));
            check("R4 model row_index", int'(rowi), mr);
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic line();
        hs = pol; tick(2);
        hs = !pol; tick(6);
    endtask

    task automatic lines(int n);
        for (int k = 0; k < n; k++) line();
    endtask

    task automatic vpulse();
        vs = pol; tick(3);
        vs = !pol; tick(5);
    endtask

    task automatic clear(logic [1:0] c);
        clr = c; tick(1);
        clr = 2'b00; tick(1);
    endtask

    initial begin
        #3_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tick(3);
        check("R1 reset pending", int'(pend), 0);
        check("R1 reset irq", int'(irq), 0);
        rst = 1'b0; tick(1);
        check("R1 after reset row_index", int'(rowi), 0);

        lines(3);
        check("R10 no row event before field edge", int'(pend[0]), 0);

        vpulse();
        check("R2 field pending", int'(pend[1]), 1);
        check("R10 row_index after field", int'(rowi), 0);
        clear(2'b11);
        check("R7 clear pulse", int'(pend), 0);

        line();
        check("R3 first row pending", int'(pend[0]), 1);
        check("R3 first row index", int'(rowi), 0);
        clear(2'b01);

        lines(17);
        check("R4 no event before 18 lines", int'(pend[0]), 0);
        line();
        check("R4 row boundary pending", int'(pend[0]), 1);
        check("R4 row index 1", int'(rowi), 1);
        clear(2'b01);

        lines(17);
        dbl = 1'b1;
        line();
        check("R5 row 2 start", int'(rowi), 2);
        clear(2'b01);
        dbl = 1'b0;
        lines(18);
        check("R5 double row no event at 18", int'(pend[0]), 0);
        check("R5 double row index held", int'(rowi), 2);
        lines(17);
        check("R5 double row no event at 35", int'(pend[0]), 0);
        line();
        check("R5 double row ends at 36", int'(pend[0]), 1);
        check("R5 row index 3", int'(rowi), 3);
        clear(2'b01);

        en = 2'b00;
        lines(18);
        check("R8 pending set while disabled", int'(pend[0]), 1);
        check("R8 irq masked", int'(irq), 0);
        check("R5 mid-row change ignored, row index 4", int'(rowi), 4);
        en = 2'b01; tick(1);
        check("R8 irq enabled row", int'(irq), 1);
        en = 2'b10; tick(1);
        check("R8 irq other source only", int'(irq), 0);
        en = 2'b11;
        clear(2'b01);

        // clear in the same cycle as the field event
        vs = pol;
        tick(2);
        clr = 2'b10; tick(1);
        clr = 2'b00;
        check("R7 set wins over clear", int'(pend[1]), 1);
        tick(1);
        vs = !pol; tick(5);
        check("R10 field edge restarts rows", int'(rowi), 0);
        clear(2'b11);

        line();
        check("R3 row 0 after field", int'(pend[0]), 1);
        clear(2'b01);
        lines(11 * 18);
        check("R6 last row index", int'(rowi), MAXR - 1);
        check("R6 last row pending", int'(pend[0]), 1);
        clear(2'b01);
        lines(18);
        check("R6 no event past last row", int'(pend[0]), 0);
        check("R6 row index saturated", int'(rowi), MAXR - 1);
        lines(10);
        check("R6 still silent", int'(pend[0]), 0);
        vpulse();
        check("R10 row index cleared by field", int'(rowi), 0);
        clear(2'b11);
        line();
        check("R10 rows resume after field", int'(pend[0]), 1);

        // active-low syncs
        rst = 1'b1; pol = 1'b0; hs = 1'b1; vs = 1'b1; tick(3);
        rst = 1'b0; tick(4);
        check("R9 idle high gives no event", int'(pend), 0);
        vs = 1'b0; tick(4);
        check("R9 falling vsync sets field", int'(pend[1]), 1);
        clear(2'b10);
        tick(10);
        check("R9 held level no retrigger", int'(pend[1]), 0);
        vs = 1'b1; tick(4);
        check("R9 release is not an edge", int'(pend[1]), 0);
        line();
        check("R9 falling hsync starts row", int'(pend[0]), 1);
        tick(2);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule